// File: doc/BRIEF.md
# Flash Page Remapping Translator

This block sits between a client that reads and writes fixed-size logical pages and a flash whose cells can only be erased a whole sector at a time. It keeps a table that holds the physical page currently owning each logical page. A write is never done in place. It is sent to the next unused page of the active sector, and the table is pointed there. A read looks up the table and is turned into a read of that physical page. A logical page that has never been written becomes a blank-fill command, so it reads as all 0xFF.

When a write lands on the final page of the active sector, the block compacts. It moves to the next sector in round-robin order, which is always erased. In ascending logical order, it issues one copy command for each logical page that has an entry, repointing the table entry as it goes. Last, it issues an erase of the sector it left. During compaction `busy` is high and no request is accepted. Writes then resume after the last copied page.

Both the request port and the command port are valid/ready streams. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low while compacting, and also while a command is pending and `cmd_ready` is low. Once `cmd_valid` is raised, it and every command field hold until the cycle `cmd_ready` is high. The design needs `PPS` to be a power of two, `LPAGES` smaller than `PPS`, and `SECTORS` of at least 2.

Top module: `flash_remap`

## Requirements
- R1: After reset, `cmd_valid` is 0, `busy` is 0 and `req_ready` is 1.
- R2: A read of a logical page that has no entry emits opcode BLANK (4) with `cmd_addr` 0.
- R3: A write emits opcode PROG (1) at the next free physical page. The physical address is sector*PPS + page. After reset the first write goes to address 0, and later writes take consecutive addresses.
- R4: A read of a written logical page emits opcode READ (0) with the address of that page's most recent PROG or COPY.
- R5: Rewriting a logical page uses a new physical page, and later reads of it return the new address.
- R6: A write to the last page of the active sector raises `busy` in the same cycle that the PROG is presented, and `req_ready` stays low while `busy` is high. Then, for each logical page with an entry, in ascending logical order, a COPY (2) is emitted. Its `cmd_src` is the page's current address and its `cmd_addr` is the next consecutive page from the start of the next sector. Then an ERASE (3) is emitted with `cmd_addr` equal to the first page of the sector that was left, and `busy` is 0 while that ERASE is presented.
- R7: After compaction, reads return the copied addresses and writes continue at the page after the last copy.
- R8: Sectors are taken in round-robin order: the sector after sector SECTORS-1 is sector 0.
- R9: While `cmd_valid` is high and `cmd_ready` is low, the command holds unchanged and `req_ready` is low. When the command is accepted in the same cycle as a new request, the next command follows with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lpage | input | clog2(LPAGES) | Logical page number |
| cmd_valid | output | 1 | Flash command present |
| cmd_ready | input | 1 | Flash sequencer takes the command |
| cmd_op | output | 3 | 0 READ, 1 PROG, 2 COPY, 3 ERASE, 4 BLANK |
| cmd_addr | output | clog2(SECTORS)+clog2(PPS) | Target physical page (sector start for ERASE) |
| cmd_src | output | clog2(SECTORS)+clog2(PPS) | Source physical page for COPY, else 0 |
| busy | output | 1 | Compaction in progress |

## Verification
The command-hold property assumes that the downstream sequencer's `cmd_ready` is a plain level. The property that an erase never targets the active sector assumes at least two sectors. The property that a write to the last page always starts compaction assumes `LPAGES` < `PPS`, so compaction never fills the new sector. The stimulus keeps to these assumptions with 3 sectors of 8 pages and 4 logical pages. It holds `cmd_ready` high except in one back-pressure window, and it changes request fields only at negative edges, before a request is taken. Write sequences are long enough to wrap the sector order back to 0, with a mix of rewritten and never-written pages.

// File: rtl/fremap_pkg.sv
package fremap_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_PROG  = 3'd1,
    OP_COPY  = 3'd2,
    OP_ERASE = 3'd3,
    OP_BLANK = 3'd4
  } fop_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_ERASE
  } fst_e;
endpackage

// File: rtl/fremap_table.sv
module fremap_table #(
  parameter int LPAGES = 128,
  parameter int LW     = 7,
  parameter int PW     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] idx,
  output logic [PW-1:0] rd_phys,
  output logic          rd_mapped,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_phys
);
  logic [PW-1:0]     ent [LPAGES];
  logic [LPAGES-1:0] mapped;

  always_ff @(posedge clk) begin
    if (!rst_n) mapped <= '0;
    else if (wr_en) mapped[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) ent[idx] <= wr_phys;
  end

  assign rd_phys   = ent[idx];
  assign rd_mapped = mapped[idx];
endmodule

// File: rtl/fremap_alloc.sv
module fremap_alloc #(
  parameter int SECTORS = 4,
  parameter int PPS     = 256,
  parameter int SEC_W   = 2,
  parameter int PG_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             rotate,
  output logic [SEC_W-1:0] cur_sec,
  output logic [PG_W-1:0]  cur_pg,
  output logic [SEC_W-1:0] old_sec,
  output logic             last
);
  localparam logic [SEC_W-1:0] SEC_MAX = SEC_W'(SECTORS - 1);
  localparam logic [PG_W-1:0]  PG_MAX  = PG_W'(PPS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_sec <= '0;
      cur_pg  <= '0;
      old_sec <= '0;
    end else if (rotate) begin
      old_sec <= cur_sec;
      cur_sec <= (cur_sec == SEC_MAX) ? '0 : cur_sec + 1'b1;
      cur_pg  <= '0;
    end else if (take) begin
      cur_pg  <= cur_pg + 1'b1;
    end
  end

  assign last = (cur_pg == PG_MAX);

  // R6: filling the final page must always start a sector change
  assert_last_rotates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last) |-> rotate);

  // R8: a sector change always lands at page 0 of the following sector
  assert_rotate_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rotate |=> (cur_pg == '0) && (old_sec != cur_sec));
endmodule

// File: rtl/flash_remap.sv
module flash_remap
  import fremap_pkg::*;
#(
  parameter int LPAGES  = 128,
  parameter int PPS     = 256,
  parameter int SECTORS = 4,
  localparam int LW     = $clog2(LPAGES),
  localparam int PG_W   = $clog2(PPS),
  localparam int SEC_W  = (SECTORS > 1) ? $clog2(SECTORS) : 1,
  localparam int PW     = SEC_W + PG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [LW-1:0] req_lpage,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [2:0]    cmd_op,
  output logic [PW-1:0] cmd_addr,
  output logic [PW-1:0] cmd_src,
  output logic          busy
);
  localparam logic [LW-1:0] SCAN_END = LW'(LPAGES - 1);

  fst_e             st;
  logic [LW-1:0]    scan_idx;
  logic             can_issue, req_fire, load;
  logic [LW-1:0]    tbl_idx;
  logic [PW-1:0]    rd_phys, cur_phys;
  logic             rd_mapped, tbl_wr;
  logic             take, rotate, last;
  logic [SEC_W-1:0] cur_sec, old_sec;
  logic [PG_W-1:0]  cur_pg;
  fop_e             n_op;
  logic [PW-1:0]    n_addr, n_src;

  assign can_issue = !cmd_valid || cmd_ready;
  assign req_ready = (st == ST_IDLE) && can_issue;
  assign req_fire  = req_valid && req_ready;
  assign busy      = (st != ST_IDLE);
  assign tbl_idx   = (st == ST_SCAN) ? scan_idx : req_lpage;
  assign cur_phys  = {cur_sec, cur_pg};

  fremap_table #(.LPAGES(LPAGES), .LW(LW), .PW(PW)) u_table (
    .clk(clk), .rst_n(rst_n), .idx(tbl_idx), .rd_phys(rd_phys),
    .rd_mapped(rd_mapped), .wr_en(tbl_wr), .wr_phys(cur_phys)
  );

  fremap_alloc #(.SECTORS(SECTORS), .PPS(PPS), .SEC_W(SEC_W), .PG_W(PG_W)) u_alloc (
    .clk(clk), .rst_n(rst_n), .take(take), .rotate(rotate),
    .cur_sec(cur_sec), .cur_pg(cur_pg), .old_sec(old_sec), .last(last)
  );

  always_comb begin
    load   = 1'b0;
    tbl_wr = 1'b0;
    take   = 1'b0;
    rotate = 1'b0;
    n_op   = OP_READ;
    n_addr = '0;
    n_src  = '0;
    unique case (st)
      ST_IDLE: if (req_fire) begin
        load = 1'b1;
        if (req_write) begin
          n_op   = OP_PROG;
          n_addr = cur_phys;
          tbl_wr = 1'b1;
          take   = 1'b1;
          rotate = last;
        end else if (rd_mapped) begin
          n_op   = OP_READ;
          n_addr = rd_phys;
        end else begin
          n_op   = OP_BLANK;
        end
      end
      ST_SCAN: if (can_issue && rd_mapped) begin
        load   = 1'b1;
        n_op   = OP_COPY;
        n_addr = cur_phys;
        n_src  = rd_phys;
        tbl_wr = 1'b1;
        take   = 1'b1;
      end
      ST_ERASE: if (can_issue) begin
        load   = 1'b1;
        n_op   = OP_ERASE;
        n_addr = {old_sec, PG_W'(0)};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      scan_idx <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_fire && req_write && last) begin
          st       <= ST_SCAN;
          scan_idx <= '0;
        end
        ST_SCAN: if (can_issue) begin
          scan_idx <= scan_idx + 1'b1;
          if (scan_idx == SCAN_END) st <= ST_ERASE;
        end
        ST_ERASE: if (can_issue) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_op    <= 3'd0;
      cmd_addr  <= '0;
      cmd_src   <= '0;
    end else if (load) begin
      cmd_valid <= 1'b1;
      cmd_op    <= n_op;
      cmd_addr  <= n_addr;
      cmd_src   <= n_src;
    end else if (cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end

  // R9: a stalled command stays put
  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_op) &&
    $stable(cmd_addr) && $stable(cmd_src));

  // R6: no request is taken during compaction
  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R6: copies always leave the sector they read from
  assert_copy_cross_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'(OP_COPY)) |->
    (cmd_src[PW-1:PG_W] != cmd_addr[PW-1:PG_W]));

  // R8: the sector being erased is never the one receiving writes
  assert_erase_other_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'(OP_ERASE)) |->
    (cmd_addr[PW-1:PG_W] != cur_sec) && (cmd_addr[PG_W-1:0] == '0));
endmodule

// File: tb/flash_remap_test.sv
module flash_remap_test;
  localparam int CLK_PERIOD = 10;
  localparam int LP = 4;
  localparam int PPS = 8;
  localparam int NS = 3;
  localparam int LW = 2;
  localparam int PW = 5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, cmd_ready = 1;
  logic [LW-1:0] req_lpage = '0;
  logic req_ready, cmd_valid, busy;
  logic [2:0] cmd_op;
  logic [PW-1:0] cmd_addr, cmd_src;

  int checks = 0, fails = 0;
  int m_map[LP];
  bit m_mapped[LP];
  int m_act = 0, m_ptr = 0;
  int exp_op[16], exp_addr[16], exp_src[16];
  string exp_rq[16];
  int n_exp;
  int last_op, last_addr;

  localparam int VN = 8;
  localparam int V_W [VN]  = '{0, 1, 1, 0, 1, 0, 0, 0};
  localparam int V_L [VN]  = '{0, 0, 1, 0, 0, 0, 3, 1};
  localparam int V_OP[VN]  = '{4, 1, 1, 0, 1, 0, 4, 0};
  localparam int V_AD[VN]  = '{0, 0, 1, 0, 2, 2, 0, 1};
  localparam string V_RQ[VN] = '{"R2", "R3", "R3", "R4", "R5", "R5", "R2", "R4"};

  flash_remap #(.LPAGES(LP), .PPS(PPS), .SECTORS(NS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_lpage(req_lpage), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_src(cmd_src), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string rq, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  task automatic push(input int op, input int ad, input int sr, input string rq);
    exp_op[n_exp] = op; exp_addr[n_exp] = ad; exp_src[n_exp] = sr;
    exp_rq[n_exp] = rq; n_exp++;
  endtask

  task automatic issue(input bit w, input int l);
    bit compact = 0;
    int idx = 0, cyc = 0, old;
    n_exp = 0;
    if (w) begin
      push(1, m_act * PPS + m_ptr, 0, "R3");
      m_map[l] = m_act * PPS + m_ptr; m_mapped[l] = 1; m_ptr++;
      if (m_ptr == PPS) begin
        compact = 1; old = m_act;
        m_act = (m_act + 1) % NS; m_ptr = 0;
        for (int k = 0; k < LP; k++) if (m_mapped[k]) begin
          push(2, m_act * PPS + m_ptr, m_map[k], (m_act == 0) ? "R8" : "R6");
          m_map[k] = m_act * PPS + m_ptr; m_ptr++;
        end
        push(3, old * PPS, 0, (m_act == 0) ? "R8" : "R6");
      end
    end else if (m_mapped[l]) push(0, m_map[l], 0, "R4");
    else push(4, 0, 0, "R2");

    @(negedge clk);
    req_valid = 1; req_write = w; req_lpage = LW'(l);
    while (!req_ready && cyc < 100) begin @(negedge clk); cyc++; end
    @(negedge clk);
    req_valid = 0;
    if (compact) chk("R6 busy during compaction", int'(busy), 1);
    cyc = 0;
    while (idx < n_exp && cyc < 100) begin
      if (cmd_valid) begin
        chk(exp_rq[idx], int'(cmd_op), exp_op[idx]);
        chk(exp_rq[idx], int'(cmd_addr), exp_addr[idx]);
        if (exp_op[idx] == 2) chk(exp_rq[idx], int'(cmd_src), exp_src[idx]);
        last_op = int'(cmd_op); last_addr = int'(cmd_addr);
        if (compact && idx == n_exp - 1) chk("R6 busy low at erase", int'(busy), 0);
        idx++;
      end
      if (idx < n_exp) begin @(negedge clk); cyc++; end
    end
    chk("command count", idx, n_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < LP; k++) begin m_map[k] = 0; m_mapped[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cmd_valid", int'(cmd_valid), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 req_ready", int'(req_ready), 1);

    for (int v = 0; v < VN; v++) begin
      issue(V_W[v] != 0, V_L[v]);
      chk(V_RQ[v], last_op, V_OP[v]);
      chk(V_RQ[v], last_addr, V_AD[v]);
    end

    issue(1, 2); issue(1, 3); issue(1, 2); issue(1, 3);
    issue(1, 0);
    issue(0, 2);
    chk("R7 read after compaction", last_addr, 10);
    issue(1, 1);
    chk("R7 write after copies", last_addr, 12);

    for (int i = 0; i < 10; i++) issue(1, i % LP);
    for (int k = 0; k < LP; k++) issue(0, k);
    chk("R8 wrapped to sector 0", m_act, 0);

    @(negedge clk);
    cmd_ready = 0; req_valid = 1; req_write = 0; req_lpage = 2'd0;
    @(negedge clk);
    req_lpage = 2'd1;
    repeat (3) begin
      @(negedge clk);
      chk("R9 held valid", int'(cmd_valid), 1);
      chk("R9 held op", int'(cmd_op), 0);
      chk("R9 held addr", int'(cmd_addr), m_map[0]);
      chk("R9 req_ready low", int'(req_ready), 0);
    end
    cmd_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R9 next command op", int'(cmd_op), 0);
    chk("R9 next command addr", int'(cmd_addr), m_map[1]);
    @(negedge clk);
    chk("R9 drained", int'(cmd_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule